// File: doc/BRIEF.md
# Conditional Jump Condition Evaluator

This block decides whether a conditional transfer of control is taken. Each cycle it may accept one request, marked by `in_valid`. A request is either a flag test or an index-loop step. A flag test evaluates a 4-bit condition code against one of two five-bit condition flag banks. The bank is either the live flags or an alternate saved copy, and the choice is made per request. A loop step moves a count value one step down or up and compares the new count with a limit. It returns both the decision and the updated count.

The block's output is registered. The decision, an illegal-request indication and the resulting count appear one cycle after the request, together with `out_valid`. A set overflow flag in the selected bank acts as a global veto. It turns every flag test into not-taken except the overflow test and the unconditional code. The block computes no target address, fetches nothing and generates no flags.

Top module: `jump_cond_eval`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears `out_valid`, `taken`, `illegal` and `count_out` to zero.
- R2: `out_valid` equals the value `in_valid` had at the previous clock edge. When `out_valid` is low, both `taken` and `illegal` are low.
- R3: Flag bits are ordered bit0 low, bit1 equal, bit2 high, bit3 overflow, bit4 carry. With `op_kind`=0 and overflow clear, the codes evaluate as follows:
  - 1: taken if low.
  - 2: taken if equal.
  - 3: taken if low or equal.
  - 4: taken if high.
  - 5: taken if not equal.
  - 6: taken if high or equal.
  - 7: taken if overflow is clear.
  - 10 (decimal 10): taken if carry.
  - 11: taken if carry is clear.
- R4: When the overflow bit of the selected bank is set, every flag test is not taken, except code 8 and code 15.
- R5: Code 8 is taken exactly when the selected overflow bit is set. Code 15 is always taken, whatever the flags.
- R6: `use_saved`=1 evaluates the code against `saved_flags` and ignores `live_flags`. `use_saved`=0 does the reverse. The code encoding is the same for both banks.
- R7: Codes 9, 12, 13 and 14 raise `illegal` and are never taken. Code 0 is never taken and is not illegal.
- R8: `op_kind`=1 (count down) returns `count_in`−1, modulo 2^32, on `count_out`. It is taken when that new count is unsigned-greater than `limit_in`.
- R9: `op_kind`=2 (count up) returns `count_in`+1, modulo 2^32. It is taken when the new count is unsigned-less-than-or-equal to `limit_in`. Loop steps never raise `illegal` and ignore the flags.
- R10: A flag test returns `count_in` unchanged on `count_out`. `op_kind`=3 raises `illegal`, is not taken and returns `count_in` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| op_kind | input | 2 | 0 flag test, 1 count down, 2 count up, 3 reserved |
| cond_code | input | 4 | Condition selector for flag tests |
| use_saved | input | 1 | 1 selects the saved flag bank |
| live_flags | input | 5 | Current flags {carry, overflow, high, equal, low} |
| saved_flags | input | 5 | Alternate saved flags, same order |
| count_in | input | 32 | Count register value |
| limit_in | input | 32 | Limit register value |
| out_valid | output | 1 | Result present |
| taken | output | 1 | Transfer of control taken |
| illegal | output | 1 | Unused code or reserved operation |
| count_out | output | 32 | Updated count (or count_in passed through) |

## Verification
The result stage is the only state, so any corruption shows up at the ports in the cycle right after the request. It can appear as a wrong `taken`, a stray `illegal`, an off-by-one `count_out` or a mistimed `out_valid`. The bench runs every code against every flag pattern in both banks. A swapped bank, a missing veto exception or a mis-decoded code therefore surfaces within one cycle of the first request that exposes it. The loop checks include wrap-around and the equal-to-limit boundary, so an error in comparison direction or signedness appears on the first such request.

// File: rtl/jce_pkg.sv
// Package: shared types and condition encodings for the jump condition evaluator.
// Assumes flag vectors are ordered {carry, overflow, high, equal, low}.
package jce_pkg;

    typedef enum logic [1:0] {
        OP_FLAG    = 2'd0,
        OP_LOOP_DN = 2'd1,
        OP_LOOP_UP = 2'd2,
        OP_RSVD    = 2'd3
    } jce_op_e;

    typedef struct packed {
        logic carry;
        logic ovf;
        logic high;
        logic equal;
        logic low;
    } jce_flags_t;

    localparam logic [3:0] CC_NEVER = 4'd0;
    localparam logic [3:0] CC_LO    = 4'd1;
    localparam logic [3:0] CC_EQ    = 4'd2;
    localparam logic [3:0] CC_LE    = 4'd3;
    localparam logic [3:0] CC_HI    = 4'd4;
    localparam logic [3:0] CC_NE    = 4'd5;
    localparam logic [3:0] CC_HE    = 4'd6;
    localparam logic [3:0] CC_NV    = 4'd7;
    localparam logic [3:0] CC_V     = 4'd8;
    localparam logic [3:0] CC_C     = 4'd10;
    localparam logic [3:0] CC_NC    = 4'd11;
    localparam logic [3:0] CC_ALL   = 4'd15;

endpackage

// File: rtl/jce_flag_test.sv
// Module: jce_flag_test
// Combinational decode of a condition code against one flag bank.
// Applies the overflow veto: a set overflow bit forces not-taken for every
// code except the overflow test and the unconditional code.
// Assumes the caller has already chosen the bank.
module jce_flag_test
    import jce_pkg::*;
(
    input  logic [3:0] code,
    input  jce_flags_t flg,
    output logic       take,
    output logic       bad_code
);

    logic raw;
    logic exempt;

    // Raw condition per code, plus detection of the unused encodings.
    always_comb begin
        raw      = 1'b0;
        bad_code = 1'b0;
        exempt   = 1'b0;
        case (code)
            CC_NEVER: raw = 1'b0;
            CC_LO:    raw = flg.low;
            CC_EQ:    raw = flg.equal;
            CC_LE:    raw = flg.low | flg.equal;
            CC_HI:    raw = flg.high;
            CC_NE:    raw = ~flg.equal;
            CC_HE:    raw = flg.high | flg.equal;
            CC_NV:    raw = ~flg.ovf;
            CC_V:     begin raw = flg.ovf; exempt = 1'b1; end
            CC_C:     raw = flg.carry;
            CC_NC:    raw = ~flg.carry;
            CC_ALL:   begin raw = 1'b1; exempt = 1'b1; end
            default:  bad_code = 1'b1;
        endcase
    end

    // Overflow veto on everything but the exempt codes.
    always_comb take = raw & (exempt | ~flg.ovf);

endmodule

// File: rtl/jce_loop_step.sv
// Module: jce_loop_step
// Combinational count step for the index-loop operations: decrement and
// test "new > limit", or increment and test "new <= limit".
// Assumes unsigned comparison and modulo-2^W wrap of the count.
module jce_loop_step #(
    parameter int CNT_W = 32
) (
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] limit,
    input  logic             dir_up,
    output logic [CNT_W-1:0] next_count,
    output logic             hit
);

    localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

    // Next count and the direction-dependent compare against the limit.
    always_comb begin
        if (dir_up) begin
            next_count = count + STEP;
            hit        = (next_count <= limit);
        end else begin
            next_count = count - STEP;
            hit        = (next_count > limit);
        end
    end

endmodule

// File: rtl/jce_out_stage.sv
// Module: jce_out_stage
// Result register: captures the decision one cycle after a valid request.
// taken and illegal are qualified by the request; the count is held between
// requests. Assumes synchronous active-low reset.
module jce_out_stage #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             d_valid,
    input  logic             d_take,
    input  logic             d_illegal,
    input  logic [CNT_W-1:0] d_count,
    output logic             q_valid,
    output logic             q_take,
    output logic             q_illegal,
    output logic [CNT_W-1:0] q_count
);

    // Register the result; count only updates on a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid   <= 1'b0;
            q_take    <= 1'b0;
            q_illegal <= 1'b0;
            q_count   <= '0;
        end else begin
            q_valid   <= d_valid;
            q_take    <= d_valid & d_take;
            q_illegal <= d_valid & d_illegal;
            if (d_valid) q_count <= d_count;
        end
    end

    AST_ILLEGAL_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        q_illegal |-> !q_take); // R7
    AST_QUALIFIED_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !q_valid |-> (!q_take && !q_illegal)); // R2

endmodule

// File: rtl/jump_cond_eval.sv
// Module: jump_cond_eval (top)
// Evaluates conditional-jump and index-loop requests; result one cycle later.
// Assumes flags arrive as {carry, overflow, high, equal, low} and that the
// overflow veto applies to flag tests only, not to loop steps.
module jump_cond_eval
    import jce_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       op_kind,
    input  logic [3:0]       cond_code,
    input  logic             use_saved,
    input  logic [4:0]       live_flags,
    input  logic [4:0]       saved_flags,
    input  logic [CNT_W-1:0] count_in,
    input  logic [CNT_W-1:0] limit_in,
    output logic             out_valid,
    output logic             taken,
    output logic             illegal,
    output logic [CNT_W-1:0] count_out
);

    jce_flags_t       sel_flags;
    jce_op_e          op;
    logic             flag_take;
    logic             flag_bad;
    logic [CNT_W-1:0] loop_next;
    logic             loop_hit;
    logic             d_take;
    logic             d_illegal;
    logic [CNT_W-1:0] d_count;

    // Bank selection and operation decode.
    always_comb begin
        sel_flags = use_saved ? jce_flags_t'(saved_flags) : jce_flags_t'(live_flags);
        op        = jce_op_e'(op_kind);
    end

    jce_flag_test u_flag (
        .code     (cond_code),
        .flg      (sel_flags),
        .take     (flag_take),
        .bad_code (flag_bad)
    );

    jce_loop_step #(.CNT_W(CNT_W)) u_loop (
        .count      (count_in),
        .limit      (limit_in),
        .dir_up     (op == OP_LOOP_UP),
        .next_count (loop_next),
        .hit        (loop_hit)
    );

    // Merge the flag-test and loop results by operation kind.
    always_comb begin
        case (op)
            OP_FLAG: begin
                d_take    = flag_take;
                d_illegal = flag_bad;
                d_count   = count_in;
            end
            OP_LOOP_DN, OP_LOOP_UP: begin
                d_take    = loop_hit;
                d_illegal = 1'b0;
                d_count   = loop_next;
            end
            default: begin
                d_take    = 1'b0;
                d_illegal = 1'b1;
                d_count   = count_in;
            end
        endcase
    end

    jce_out_stage #(.CNT_W(CNT_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .d_valid   (in_valid),
        .d_take    (d_take),
        .d_illegal (d_illegal),
        .d_count   (d_count),
        .q_valid   (out_valid),
        .q_take    (taken),
        .q_illegal (illegal),
        .q_count   (count_out)
    );

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_IDLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_kind == 2'd0 && cond_code == 4'd15) |=> taken); // R5
    AST_OVERFLOW_VETO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_kind == 2'd0 && cond_code != 4'd8 && cond_code != 4'd15
         && (use_saved ? saved_flags[3] : live_flags[3])) |=> !taken); // R4
    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_kind == 2'd1) |=> (count_out == $past(count_in) - CNT_W'(1))); // R8
    AST_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_kind == 2'd2) |=> (count_out == $past(count_in) + CNT_W'(1))); // R9
    AST_FLAG_PASS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_kind == 2'd0) |=> (count_out == $past(count_in))); // R10

endmodule

// File: tb/tb_jump_cond_eval.sv
module tb_jump_cond_eval;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op_kind = '0;
    logic [3:0]  cond_code = '0;
    logic        use_saved = 1'b0;
    logic [4:0]  live_flags = '0;
    logic [4:0]  saved_flags = '0;
    logic [31:0] count_in = '0;
    logic [31:0] limit_in = '0;
    logic        out_valid;
    logic        taken;
    logic        illegal;
    logic [31:0] count_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit          v;
        bit          tk;
        bit          il;
        logic [31:0] cnt;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    logic [31:0] held_cnt = '0;

    always #2.5 clk = ~clk;

    jump_cond_eval dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_kind(op_kind),
        .cond_code(cond_code), .use_saved(use_saved), .live_flags(live_flags),
        .saved_flags(saved_flags), .count_in(count_in), .limit_in(limit_in),
        .out_valid(out_valid), .taken(taken), .illegal(illegal), .count_out(count_out)
    );

    // Behavioural model of one request, written from the requirements.
    function automatic exp_t model(bit v, int kind, int code, bit sv,
                                   logic [4:0] lf, logic [4:0] sf,
                                   logic [31:0] c, logic [31:0] lim);
        exp_t e;
        logic [4:0] f;
        bit lo, eq, hi, ov, cy, t;
        e.v = v; e.tk = 0; e.il = 0; e.cnt = held_cnt; e.tag = "R2";
        if (!v) return e;
        f  = sv ? sf : lf;
        lo = f[0]; eq = f[1]; hi = f[2]; ov = f[3]; cy = f[4];
        if (kind == 0) begin
            e.cnt = c;
            t = 0;
            if (code == 9 || code == 12 || code == 13 || code == 14) begin
                e.il = 1; e.tag = "R7";
            end else if (code == 15) begin
                t = 1; e.tag = "R5";
            end else if (code == 8) begin
                t = ov; e.tag = "R5";
            end else if (ov) begin
                t = 0; e.tag = "R4";
            end else begin
                e.tag = sv ? "R6" : "R3";
                if (code == 0) begin t = 0; e.tag = "R7"; end
                if (code == 1) t = lo;
                if (code == 2) t = eq;
                if (code == 3) t = lo || eq;
                if (code == 4) t = hi;
                if (code == 5) t = !eq;
                if (code == 6) t = hi || eq;
                if (code == 7) t = 1;
                if (code == 10) t = cy;
                if (code == 11) t = !cy;
            end
            e.tk = t;
        end else if (kind == 1) begin
            e.cnt = c - 32'd1; e.tk = (e.cnt > lim); e.tag = "R8";
        end else if (kind == 2) begin
            e.cnt = c + 32'd1; e.tk = (e.cnt <= lim); e.tag = "R9";
        end else begin
            e.cnt = c; e.il = 1; e.tag = "R10";
        end
        return e;
    endfunction

    // Compare outputs with the oldest expectation at the falling edge.
    task automatic compare();
        exp_t e;
        if (exp_q.size() == 0) return;
        e = exp_q.pop_front();
        checks++;
        if (out_valid !== e.v || taken !== e.tk || illegal !== e.il ||
            (e.v && count_out !== e.cnt)) begin
            errors++;
            $display("FAIL %s: got v=%0b tk=%0b il=%0b cnt=%h, expected v=%0b tk=%0b il=%0b cnt=%h",
                     e.tag, out_valid, taken, illegal, count_out, e.v, e.tk, e.il, e.cnt);
        end
        if (e.v) held_cnt = e.cnt;
    endtask

    task automatic step(bit v, int kind, int code, bit sv, logic [4:0] lf,
                        logic [4:0] sf, logic [31:0] c, logic [31:0] lim);
        exp_t e;
        @(negedge clk);
        compare();
        in_valid = v; op_kind = kind[1:0]; cond_code = code[3:0]; use_saved = sv;
        live_flags = lf; saved_flags = sf; count_in = c; limit_in = lim;
        if (v) e = model(v, kind, code, sv, lf, sf, c, lim);
        else begin
            e = model(v, kind, code, sv, lf, sf, c, lim);
        end
        exp_q.push_back(e);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        for (int n = 0; n < 100000; n++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            $display("FAIL watchdog: R2 run did not complete, got hang, expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state, even with a request presented.
        in_valid = 1'b1; op_kind = 2'd0; cond_code = 4'd15; count_in = 32'hDEAD_BEEF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 0 || taken !== 0 || illegal !== 0 || count_out !== 0) begin
            errors++;
            $display("FAIL R1: got v=%0b tk=%0b il=%0b cnt=%h, expected all zero",
                     out_valid, taken, illegal, count_out);
        end
        in_valid = 1'b0;
        rst_n = 1'b1;

        // R3, R4, R5, R7: every code against every live flag pattern.
        for (int code = 0; code < 16; code++)
            for (int f = 0; f < 32; f++)
                step(1, 0, code, 0, f[4:0], ~f[4:0], 32'h100 + f, 32'h0);

        // R6: saved bank selected, live bank set to the complement.
        for (int code = 0; code < 16; code++)
            for (int f = 0; f < 32; f++)
                step(1, 0, code, 1, ~f[4:0], f[4:0], 32'h200 + f, 32'h0);

        // R2: idle gaps interleaved with requests.
        step(0, 0, 15, 0, 5'd0, 5'd0, 32'h0, 32'h0);
        step(1, 0, 15, 0, 5'd0, 5'd0, 32'h55, 32'h0);
        step(0, 0, 15, 0, 5'd0, 5'd0, 32'h66, 32'h0);
        step(0, 0, 9, 0, 5'd0, 5'd0, 32'h0, 32'h0);

        // R8: count down, boundaries around the limit and wrap.
        step(1, 1, 0, 0, 5'h1F, 5'h1F, 32'd5, 32'd4);
        step(1, 1, 0, 0, 5'h08, 5'h08, 32'd6, 32'd4);
        step(1, 1, 0, 0, 5'h00, 5'h00, 32'd0, 32'd4);
        step(1, 1, 0, 0, 5'h00, 5'h00, 32'h8000_0000, 32'h7FFF_FFFF);
        step(1, 1, 0, 0, 5'h00, 5'h00, 32'h8000_0001, 32'h7FFF_FFFF);

        // R9: count up, equal-to-limit, above-limit and wrap.
        step(1, 2, 0, 0, 5'h08, 5'h08, 32'd3, 32'd4);
        step(1, 2, 0, 0, 5'h00, 5'h00, 32'd4, 32'd4);
        step(1, 2, 0, 0, 5'h00, 5'h00, 32'hFFFF_FFFF, 32'd0);
        step(1, 2, 0, 0, 5'h00, 5'h00, 32'h7FFF_FFFF, 32'h8000_0000);

        // R10: reserved operation kind.
        step(1, 3, 15, 0, 5'h00, 5'h00, 32'h1234_5678, 32'hFFFF_FFFF);
        step(1, 3, 1, 1, 5'h01, 5'h01, 32'h0000_0009, 32'h0);

        // Drain the pipeline.
        step(0, 0, 0, 0, 5'h0, 5'h0, 32'h0, 32'h0);
        step(0, 0, 0, 0, 5'h0, 5'h0, 32'h0, 32'h0);
        @(negedge clk);
        compare();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule